// File: doc/BRIEF.md
# Exponential ADSR Envelope Generator

This block turns a gate signal and four 10-bit shape settings (attack, decay, sustain, release) into a 10-bit envelope level for a downstream PWM or DAC stage. The level is recomputed once for each `tick` strobe. Between strobes it holds still. Every segment follows one exponential curve. The curve comes from a 256-entry table of a decaying exponential, computed at elaboration, and the block interpolates linearly between neighbouring entries using a 16-bit phase.

Attack aims past full scale and is clipped at full scale, which gives it a sharp knee at the top. Decay and release share a single falling segment. That segment scales the curve and adds an offset: the sustain level during decay, and zero during release. A hold-off counter rejects contact bounce on the gate. After a gate press is accepted, further gate changes are ignored for a fixed number of ticks.

Each segment's phase step is looked up in the same exponential table. The index is the matching shape setting with its two low bits dropped. The table entry is then divided by 256, with a floor of 1. A small setting therefore gives a fast segment, and a large setting gives a slow one.

Top module: `env_adsr_gen`

## Requirements
- R1: A synchronous active-high reset sets the envelope to 0, the segment to idle and the hold-off counter to 0.
- R2: The envelope changes only on a clock edge where `tick` is high. On every other edge it keeps its value.
- R3: The curve table holds T[0] = 65535 and T[i] = floor(T[i-1] × 63717 / 65536) for i = 1 to 255.
- R4: curve(p) takes i = p[15:8] and f = p[7:0]. It uses n = T[i+1], or n = 0 when i = 255, and returns n + floor((T[i] − n) × (255 − f) / 256).
- R5: The phase step for a segment is floor(T[s >> 2] / 256), forced to 1 when that gives 0. Here s is the setting that applies: attack on press, release on release, decay at the attack knee.
- R6: The gate is active low. A tick that sees the gate low while the hold-off counter is 0 starts attack. It loads the counter with 100, sets the phase to 0 and the aim to 1200, and takes the attack step.
- R7: Each tick first decrements the hold-off counter when it is above 1. The gate is then examined only if the counter is 0 or 1. A low gate with the counter at 1 does nothing.
- R8: A tick that sees the gate high with the counter (after its decrement) at 1 clears the counter. If the envelope is 0, the segment goes idle. Otherwise it falls, with scale equal to the envelope, offset 0, phase 0 and the release step.
- R9: In attack, the envelope is floor((65535 − curve(phase)) × 1200 / 65536), and the phase then advances by the step. On the tick that enters attack, phase 0 is used.
- R10: When the attack value reaches 1023 or more, the envelope becomes 1023. The segment switches to falling, with offset equal to sustain, scale equal to 1023 − sustain, phase 0 and the decay step.
- R11: While falling, the envelope is floor(curve(phase) × scale / 65536) + offset. If 65535 − phase ≤ step, the segment goes idle with phase 0. Otherwise the phase advances by the step.
- R12: In idle, ticks that carry no accepted gate event leave the envelope unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle update strobe |
| gate_n | input | 1 | Gate, active low, already synchronous to clk |
| attack_p | input | 10 | Attack speed setting |
| decay_p | input | 10 | Decay speed setting |
| sustain_p | input | 10 | Sustain level |
| release_p | input | 10 | Release speed setting |
| env | output | 10 | Envelope level, 0 to 1023 |

## Verification
The assertions assume that `gate_n` and the four settings are already synchronous to `clk`, and that `tick` is a plain level, either single-cycle or held. The settings may change between ticks, because only the values present on a tick that loads a step or sustain level take effect. The stimulus changes every input on the falling clock edge. It sends ticks both back to back and separated by idle cycles. It bounces the gate inside the hold-off window. It also drives sustain to both extremes, so the falling segment is seen with zero scale as well as with full scale.

// File: rtl/envgen_pkg.sv
package envgen_pkg;

  localparam int unsigned PH_W      = 16;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned FR_W      = PH_W - IDX_W;
  localparam int unsigned ROM_DEPTH = 1 << IDX_W;
  localparam logic [PH_W-1:0] PH_MAX = '1;

  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_RISE = 2'd1,
    SEG_FALL = 2'd2
  } seg_e;

  // Entry idx of the exponential table: repeated multiply by k/2^PH_W.
  function automatic logic [PH_W-1:0] rom_entry(input int unsigned idx,
                                                input int unsigned k);
    logic [31:0] v;
    v = 32'(PH_MAX);
    for (int unsigned i = 0; i < idx; i++) begin
      v = 32'((64'(v) * 64'(k)) >> PH_W);
    end
    return v[PH_W-1:0];
  endfunction

  // Linear blend between two neighbouring table words.
  function automatic logic [PH_W-1:0] curve_interp(input logic [PH_W-1:0] here,
                                                   input logic [PH_W-1:0] nxt,
                                                   input logic [FR_W-1:0] frac);
    logic [31:0] span;
    span = 32'(here - nxt) * 32'({FR_W{1'b1}} - frac);
    return nxt + PH_W'(span >> FR_W);
  endfunction

  // Phase increment derived from a table word, never zero.
  function automatic logic [PH_W-1:0] step_of(input logic [PH_W-1:0] word);
    logic [PH_W-1:0] s;
    s = word >> IDX_W;
    if (s == '0) begin
      s = PH_W'(1);
    end
    return s;
  endfunction

  function automatic logic [31:0] rise_level(input logic [PH_W-1:0] c,
                                             input logic [31:0] scale);
    return (32'(PH_MAX - c) * scale) >> PH_W;
  endfunction

  function automatic logic [31:0] fall_level(input logic [PH_W-1:0] c,
                                             input logic [31:0] scale,
                                             input logic [31:0] offset);
    return ((32'(c) * scale) >> PH_W) + offset;
  endfunction

endpackage

// File: rtl/env_exp_rom.sv
module env_exp_rom
  import envgen_pkg::*;
#(
  parameter int unsigned DECAY_K = 63717,
  parameter int unsigned PORTS   = 3
) (
  input  logic [PORTS-1:0][IDX_W-1:0] rd_addr,
  output logic [PORTS-1:0][PH_W-1:0]  rd_data
);

  logic [PH_W-1:0] table_w [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_entry
    localparam logic [PH_W-1:0] WORD = rom_entry(g, DECAY_K);
    assign table_w[g] = WORD;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign rd_data[p] = table_w[rd_addr[p]];
  end

endmodule

// File: rtl/env_holdoff.sv
module env_holdoff #(
  parameter int unsigned HOLDOFF = 100,
  parameter int unsigned CNT_W   = $clog2(HOLDOFF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate_n,
  output logic             press_ev,
  output logic             release_ev,
  output logic [CNT_W-1:0] hold_cnt
);

  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLDOFF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_dec;

  // countdown happens before the gate is looked at
  assign cnt_dec    = (cnt_q > ONE) ? cnt_q - ONE : cnt_q;
  assign press_ev   = tick && !gate_n && (cnt_dec == '0);
  assign release_ev = tick && gate_n && (cnt_dec <= ONE) && (cnt_dec != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (press_ev) begin
        cnt_q <= RELOAD;
      end else if (release_ev) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_dec;
      end
    end
  end

  assign hold_cnt = cnt_q;

endmodule

// File: rtl/env_shaper.sv
module env_shaper
  import envgen_pkg::*;
#(
  parameter int unsigned VAL_W    = 10,
  parameter int unsigned RISE_AIM = 1200,
  parameter int unsigned SC_W     = $clog2(RISE_AIM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             press_ev,
  input  logic             release_ev,
  input  logic [VAL_W-1:0] attack_p,
  input  logic [VAL_W-1:0] decay_p,
  input  logic [VAL_W-1:0] sustain_p,
  input  logic [VAL_W-1:0] release_p,
  input  logic [PH_W-1:0]  here_word,
  input  logic [PH_W-1:0]  next_word,
  input  logic [PH_W-1:0]  step_word,
  output logic [IDX_W-1:0] here_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic [IDX_W-1:0] step_idx,
  output seg_e             seg,
  output logic             attack_done,
  output logic [VAL_W-1:0] env
);

  localparam logic [VAL_W-1:0] VAL_MAX = '1;

  seg_e             seg_q, seg_g, seg_n;
  logic [PH_W-1:0]  phase_q, phase_g, phase_n;
  logic [PH_W-1:0]  step_q, step_g, step_n, step_new;
  logic [SC_W-1:0]  scale_q, scale_g, scale_n;
  logic [VAL_W-1:0] offs_q, offs_g, offs_n;
  logic [VAL_W-1:0] env_q, env_n;
  logic [VAL_W-1:0] step_src;
  logic [PH_W-1:0]  nxt_g, curve_g;
  logic [31:0]      rise_lvl;
  logic [VAL_W-1:0] fall_env;
  logic             clip_g, fall_end_g;

  // which setting feeds the step lookup this tick
  assign step_src = press_ev   ? attack_p  :
                    release_ev ? release_p : decay_p;
  assign step_idx = IDX_W'(step_src >> (VAL_W - IDX_W));
  assign step_new = step_of(step_word);

  // stage 1: gate events rewrite the segment context
  always_comb begin : gate_stage
    seg_g   = seg_q;
    phase_g = phase_q;
    step_g  = step_q;
    scale_g = scale_q;
    offs_g  = offs_q;
    if (press_ev) begin
      seg_g   = SEG_RISE;
      phase_g = '0;
      scale_g = SC_W'(RISE_AIM);
      offs_g  = '0;
      step_g  = step_new;
    end else if (release_ev) begin
      phase_g = '0;
      if (env_q == '0) begin
        seg_g = SEG_IDLE;
      end else begin
        seg_g   = SEG_FALL;
        scale_g = SC_W'(env_q);
        offs_g  = '0;
        step_g  = step_new;
      end
    end
  end

  // curve sample at the stage-1 phase
  assign here_idx   = phase_g[PH_W-1 -: IDX_W];
  assign next_idx   = here_idx + IDX_W'(1);
  assign nxt_g      = (here_idx == '1) ? '0 : next_word;
  assign curve_g    = curve_interp(here_word, nxt_g, phase_g[FR_W-1:0]);
  assign rise_lvl   = rise_level(curve_g, 32'(scale_g));
  assign fall_env   = VAL_W'(fall_level(curve_g, 32'(scale_g), 32'(offs_g)));
  assign clip_g     = (seg_g == SEG_RISE) && (rise_lvl >= 32'(VAL_MAX));
  assign fall_end_g = (PH_MAX - phase_g) <= step_g;

  // stage 2: segment action
  always_comb begin : seg_stage
    seg_n   = seg_g;
    phase_n = phase_g;
    step_n  = step_g;
    scale_n = scale_g;
    offs_n  = offs_g;
    env_n   = env_q;
    case (seg_g)
      SEG_RISE: begin
        if (clip_g) begin
          env_n   = VAL_MAX;
          seg_n   = SEG_FALL;
          offs_n  = sustain_p;
          scale_n = SC_W'(VAL_MAX - sustain_p);
          phase_n = '0;
          step_n  = step_new;
        end else begin
          env_n   = VAL_W'(rise_lvl);
          phase_n = phase_g + step_g;
        end
      end
      SEG_FALL: begin
        env_n = fall_env;
        if (fall_end_g) begin
          seg_n   = SEG_IDLE;
          phase_n = '0;
        end else begin
          phase_n = phase_g + step_g;
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q   <= SEG_IDLE;
      phase_q <= '0;
      step_q  <= PH_W'(1);
      scale_q <= '0;
      offs_q  <= '0;
      env_q   <= '0;
    end else if (tick) begin
      seg_q   <= seg_n;
      phase_q <= phase_n;
      step_q  <= step_n;
      scale_q <= scale_n;
      offs_q  <= offs_n;
      env_q   <= env_n;
    end
  end

  assign seg         = seg_q;
  assign attack_done = tick && clip_g;
  assign env         = env_q;

endmodule

// File: rtl/env_adsr_gen.sv
module env_adsr_gen
  import envgen_pkg::*;
#(
  parameter int unsigned VAL_W    = 10,
  parameter int unsigned HOLDOFF  = 100,
  parameter int unsigned RISE_AIM = 1200,
  parameter int unsigned DECAY_K  = 63717
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate_n,
  input  logic [VAL_W-1:0] attack_p,
  input  logic [VAL_W-1:0] decay_p,
  input  logic [VAL_W-1:0] sustain_p,
  input  logic [VAL_W-1:0] release_p,
  output logic [VAL_W-1:0] env
);

  localparam int unsigned CNT_W = $clog2(HOLDOFF + 1);
  localparam int unsigned NPORT = 3;

  // internal events brought out for the checker
  logic             press_ev;
  logic             release_ev;
  logic             attack_done;
  logic [CNT_W-1:0] hold_cnt;
  seg_e             seg;

  logic [IDX_W-1:0] here_idx, next_idx, step_idx;
  logic [NPORT-1:0][IDX_W-1:0] rom_addr;
  logic [NPORT-1:0][PH_W-1:0]  rom_data;

  env_holdoff #(
    .HOLDOFF (HOLDOFF),
    .CNT_W   (CNT_W)
  ) u_holdoff (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .gate_n     (gate_n),
    .press_ev   (press_ev),
    .release_ev (release_ev),
    .hold_cnt   (hold_cnt)
  );

  assign rom_addr[0] = here_idx;
  assign rom_addr[1] = next_idx;
  assign rom_addr[2] = step_idx;

  env_exp_rom #(
    .DECAY_K (DECAY_K),
    .PORTS   (NPORT)
  ) u_rom (
    .rd_addr (rom_addr),
    .rd_data (rom_data)
  );

  env_shaper #(
    .VAL_W    (VAL_W),
    .RISE_AIM (RISE_AIM)
  ) u_shaper (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .press_ev    (press_ev),
    .release_ev  (release_ev),
    .attack_p    (attack_p),
    .decay_p     (decay_p),
    .sustain_p   (sustain_p),
    .release_p   (release_p),
    .here_word   (rom_data[0]),
    .next_word   (rom_data[1]),
    .step_word   (rom_data[2]),
    .here_idx    (here_idx),
    .next_idx    (next_idx),
    .step_idx    (step_idx),
    .seg         (seg),
    .attack_done (attack_done),
    .env         (env)
  );

endmodule

// File: rtl/env_adsr_checker.sv
module env_adsr_checker
  import envgen_pkg::*;
#(
  parameter int unsigned VAL_W   = 10,
  parameter int unsigned HOLDOFF = 100,
  parameter int unsigned CNT_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             press_ev,
  input logic             release_ev,
  input logic             attack_done,
  input seg_e             seg,
  input logic [CNT_W-1:0] hold_cnt,
  input logic [VAL_W-1:0] env
);

  localparam logic [VAL_W-1:0] VAL_MAX = '1;

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(env));

  a_r6_press_arms: assert property (@(posedge clk) disable iff (rst)
    press_ev |=> (seg == SEG_RISE) && (hold_cnt == CNT_W'(HOLDOFF)));

  a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
    tick && (hold_cnt > CNT_W'(1)) && !release_ev |=> hold_cnt == $past(hold_cnt) - CNT_W'(1));

  a_r8_release_disarms: assert property (@(posedge clk) disable iff (rst)
    release_ev |=> (hold_cnt == '0) && (seg != SEG_RISE));

  a_r10_knee_clamp: assert property (@(posedge clk) disable iff (rst)
    attack_done |=> (env == VAL_MAX) && (seg == SEG_FALL));

  a_r11_fall_nonrising: assert property (@(posedge clk) disable iff (rst)
    tick && (seg == SEG_FALL) && !press_ev |=> env <= $past(env));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    tick && (seg == SEG_IDLE) && !press_ev && !release_ev |=> $stable(env));

endmodule

bind env_adsr_gen env_adsr_checker #(
  .VAL_W   (VAL_W),
  .HOLDOFF (HOLDOFF),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .press_ev    (press_ev),
  .release_ev  (release_ev),
  .attack_done (attack_done),
  .seg         (seg),
  .hold_cnt    (hold_cnt),
  .env         (env)
);

// File: tb/tb_env_adsr_gen.sv
module tb_env_adsr_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       gate_n = 1'b1;
  logic [9:0] attack_p = '0;
  logic [9:0] decay_p = '0;
  logic [9:0] sustain_p = '0;
  logic [9:0] release_p = '0;
  logic [9:0] env;

  always #4 clk = ~clk;   // 125 MHz

  env_adsr_gen dut (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .gate_n    (gate_n),
    .attack_p  (attack_p),
    .decay_p   (decay_p),
    .sustain_p (sustain_p),
    .release_p (release_p),
    .env       (env)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  // ---------------- reference model, written from the requirements
  int tbl [256];
  int m_seg = 0;      // 0 idle, 1 attack, 2 falling
  int m_cnt = 0;
  int m_phase = 0;
  int m_step = 1;
  int m_scale = 0;
  int m_offs = 0;
  int m_env = 0;
  int last_exp = 0;
  bit mon_on = 0;

  function automatic int bcurve(input int p);
    int i, f, n;
    i = p / 256;
    f = p % 256;
    n = (i == 255) ? 0 : tbl[i + 1];
    return n + ((tbl[i] - n) * (255 - f)) / 256;
  endfunction

  function automatic int bstep(input int setting);
    int s;
    s = tbl[setting / 4] / 256;
    return (s < 1) ? 1 : s;
  endfunction

  task automatic model_tick(input logic gn);
    int lvl;
    if (m_cnt > 1) m_cnt = m_cnt - 1;
    if (m_cnt <= 1) begin
      if (gn == 1'b0) begin
        if (m_cnt == 0) begin
          m_cnt = 100; m_seg = 1; m_phase = 0; m_scale = 1200;
          m_step = bstep(int'(attack_p));
        end
      end else if (m_cnt != 0) begin
        m_phase = 0;
        if (m_env == 0) m_seg = 0;
        else begin
          m_seg = 2; m_scale = m_env; m_offs = 0;
          m_step = bstep(int'(release_p));
        end
        m_cnt = 0;
      end
    end
    if (m_seg == 1) begin
      lvl = ((65535 - bcurve(m_phase)) * m_scale) / 65536;
      if (lvl >= 1023) begin
        m_env = 1023; m_seg = 2; m_offs = int'(sustain_p);
        m_scale = 1023 - int'(sustain_p); m_phase = 0;
        m_step = bstep(int'(decay_p));
      end else begin
        m_env = lvl;
        m_phase = (m_phase + m_step) % 65536;
      end
    end else if (m_seg == 2) begin
      m_env = (bcurve(m_phase) * m_scale) / 65536 + m_offs;
      if (65535 - m_phase <= m_step) begin
        m_seg = 0; m_phase = 0;
      end else begin
        m_phase = m_phase + m_step;
      end
    end
  endtask

  // ---------------- driver
  task automatic pulse(input logic gn, input string tg);
    item_t it;
    gate_n = gn;
    tick = 1'b1;
    model_tick(gn);
    it.exp = m_env;
    it.tag = tg;
    sb_q.push_back(it);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulses(input int n, input logic gn, input string tg);
    for (int i = 0; i < n; i++) pulse(gn, tg);
  endtask

  task automatic chk_eq(input string tg, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tg, act, exp);
    end
  endtask

  // ---------------- monitor (scoreboard)
  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      if (mon_on) begin
        if (tick) begin
          #2;
          checks++;
          if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL R2 tick with empty scoreboard actual %0d expected none", env);
          end else begin
            it = sb_q.pop_front();
            last_exp = it.exp;
            if (int'(env) != it.exp) begin
              errors++;
              $display("FAIL %s actual %0d expected %0d", it.tag, env, it.exp);
            end
          end
        end else begin
          #2;
          checks++;
          if (int'(env) != last_exp) begin
            errors++;
            $display("FAIL R2 no-tick hold actual %0d expected %0d", env, last_exp);
          end
        end
      end
    end
  end

  // ---------------- watchdog
  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus
  initial begin : stim
    int e0;
    tbl[0] = 65535;   // R3 table recurrence
    for (int i = 1; i < 256; i++) tbl[i] = int'((longint'(tbl[i - 1]) * 63717) / 65536);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk_eq("R1 reset level", int'(env), 0);
    mon_on = 1;

    attack_p = 10'd0; decay_p = 10'd200; sustain_p = 10'd600; release_p = 10'd100;
    pulses(5, 1'b1, "R12 idle gate high");
    repeat (3) @(negedge clk);   // R2: no ticks

    // fast attack with bounce inside hold-off
    pulses(30, 1'b0, "R6/R9/R3/R4 attack");
    e0 = int'(env);
    pulses(20, 1'b1, "R7 bounce ignored");
    chk_eq("R7 attack kept rising through bounce", int'(int'(env) > e0), 1);
    pulses(1300, 1'b0, "R10/R11/R5 knee and decay");
    chk_eq("R11 settles at sustain", int'(env), 600);
    pulses(10, 1'b0, "R12 idle at sustain");
    chk_eq("R12 sustain held", int'(env), 600);

    // release
    pulses(600, 1'b1, "R8/R11 release");
    chk_eq("R11 release ends at zero", int'(env), 0);
    pulses(5, 1'b1, "R12 idle after release");

    // slow attack (minimum step), early release, re-press
    attack_p = 10'd1023;
    pulses(150, 1'b0, "R5/R9 slow attack");
    pulses(40, 1'b1, "R8 release from low level");
    attack_p = 10'd0; decay_p = 10'd0; sustain_p = 10'd1023;
    pulse(1'b0, "R6 re-press with counter clear");
    chk_eq("R6 re-press restarts from phase 0", int'(env), 0);
    pulses(400, 1'b0, "R10 zero-scale decay");
    chk_eq("R10 full sustain holds peak", int'(env), 1023);

    // slowest release, first part with gaps between ticks
    release_p = 10'd1023; sustain_p = 10'd0;
    for (int i = 0; i < 100; i++) begin
      pulse(1'b1, "R11/R2 gapped release");
      @(negedge clk);
    end
    pulses(65500, 1'b1, "R11/R5 slow release");
    chk_eq("R11 slow release reaches zero", int'(env), 0);

    @(negedge clk);
    chk_eq("R2 scoreboard drained", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule